// File: doc/BRIEF.md
# Shared-Exponent Colour Word Decoder

This block unpacks one 32-bit colour word, in which three 9-bit unsigned channel mantissas share a single 5-bit exponent, into three IEEE-754 single-precision channel values and a constant opacity of 1.0. The channel mantissas carry no hidden leading one. Each channel is therefore its plain integer mantissa times two raised to the shared exponent minus 24. That offset is the exponent bias of 15 plus the 9 mantissa bits. The word has no sign bit and no encodings for infinity or not-a-number.

The conversion is combinational per channel. A leading-one search renormalises the integer mantissa into a float fraction, and the shared exponent is rebiased to the float exponent. One output register stage with a valid flag closes the path. A texture-sampling or pixel pipeline feeds a word with `valid_i` and takes four float values one clock later.

Top module: `rgb9e5_decode`

## Requirements
- R1: While `rst_ni` is low and after its release until the first accepted word, `valid_o` is 0 and all four float outputs are 32'h0000_0000.
- R2: `valid_o` is high in exactly those cycles that follow a clock edge at which `valid_i` was high, giving a latency of one clock.
- R3: The input fields are red mantissa at bits 8:0, green at 17:9, blue at 26:18, and the shared exponent as an unsigned value at bits 31:27.
- R4: A channel whose mantissa is zero outputs 32'h0000_0000 (+0.0) for every exponent value.
- R5: For a nonzero mantissa whose highest set bit is bit k, the output has sign bit 31 clear and exponent field bits 30:23 equal to E + k + 103. The mantissa bits below bit k, left-aligned, form fraction bits 22:15, and fraction bits 14:0 are zero.
- R6: Every output equals mantissa × 2^(E−24) exactly. Examples: mantissa 1 with E=0 gives 32'h3380_0000, mantissa 1 with E=24 gives 32'h3F80_0000, and mantissa 511 with E=31 gives 32'h477F_8000.
- R7: Whenever `valid_o` is high, `alpha_o` is 32'h3F80_0000 (1.0).
- R8: In a cycle where `valid_i` is low, `word_i` has no effect: all four float outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word qualifier |
| word_i | input | 32 | Packed shared-exponent colour word |
| valid_o | output | 1 | Output qualifier, one clock after `valid_i` |
| red_o | output | 32 | Red channel, single precision |
| green_o | output | 32 | Green channel, single precision |
| blue_o | output | 32 | Blue channel, single precision |
| alpha_o | output | 32 | Opacity, always 1.0 when valid |

## Verification
The bench first applies zero mantissas under extreme exponents. A design that treated zero as a denormal seed, or that added the exponent offset unconditionally, would return a tiny nonzero float there instead of +0.0. It then applies single-bit mantissas at each bit position and the all-ones mantissa under both exponent extremes. These cases catch an off-by-one leading-one position, a fraction taken with the hidden bit still in it, or a wrong rebias constant, and each of those shows up as a value off by a power of two or a fraction shifted by one place. Words with distinct values in each field catch swapped or misaligned channel slices and a signed exponent extraction. Changing `word_i` while `valid_i` is low catches a register that loads without its enable.

// File: rtl/rgb9e5_pkg.sv
package rgb9e5_pkg;
  localparam int unsigned NUM_CH      = 3;
  localparam int unsigned FP_W        = 32;
  localparam int unsigned FP_EXP_W    = 8;
  localparam int unsigned FP_FRAC_W   = 23;
  localparam int          FP_EXP_BIAS = 127;
  localparam logic [FP_W-1:0] FP_ONE  = 32'h3F80_0000;
  localparam logic [FP_W-1:0] FP_ZERO = 32'h0000_0000;
endpackage

// File: rtl/rgb9e5_lead_one.sv
module rgb9e5_lead_one #(
  parameter int unsigned W     = 9,
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // ascending scan: last hit is the highest set bit
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/rgb9e5_chan.sv
module rgb9e5_chan
  import rgb9e5_pkg::*;
#(
  parameter int unsigned MANT_W   = 9,
  parameter int unsigned EXP_W    = 5,
  parameter int          EXP_BIAS = 15
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [FP_W-1:0]   fp_o
);
  localparam int unsigned IDX_W   = (MANT_W > 1) ? $clog2(MANT_W) : 1;
  localparam int          EXP_OFS = FP_EXP_BIAS - EXP_BIAS - int'(MANT_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MANT_W - 1);
  localparam int unsigned PAD_W   = FP_FRAC_W - (MANT_W - 1);

  logic [IDX_W-1:0]     lead_idx;
  logic                 nonzero;
  logic [MANT_W-1:0]    norm;
  logic [FP_EXP_W-1:0]  fexp;
  logic [FP_FRAC_W-1:0] frac;

  rgb9e5_lead_one #(.W(MANT_W)) lead_i (
    .vec_i (mant_i),
    .idx_o (lead_idx),
    .any_o (nonzero)
  );

  // move the leading one to the top, then drop it as the hidden bit
  assign norm = mant_i << (TOP_IDX - lead_idx);
  assign frac = {norm[MANT_W-2:0], {PAD_W{1'b0}}};
  assign fexp = FP_EXP_W'(int'(exp_i) + int'(lead_idx) + EXP_OFS);
  assign fp_o = nonzero ? {1'b0, fexp, frac} : FP_ZERO;
endmodule

// File: rtl/rgb9e5_decode.sv
module rgb9e5_decode
  import rgb9e5_pkg::*;
#(
  parameter int unsigned MANT_W   = 9,
  parameter int unsigned EXP_W    = 5,
  parameter int          EXP_BIAS = 15,
  localparam int unsigned WORD_W  = NUM_CH * MANT_W + EXP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [FP_W-1:0]   red_o,
  output logic [FP_W-1:0]   green_o,
  output logic [FP_W-1:0]   blue_o,
  output logic [FP_W-1:0]   alpha_o
);
  logic [EXP_W-1:0] shared_exp;
  logic [FP_W-1:0]  ch_fp [NUM_CH];
  logic [FP_W-1:0]  ch_q  [NUM_CH];
  logic [FP_W-1:0]  alpha_q;
  logic             valid_q;

  assign shared_exp = word_i[WORD_W-1 -: EXP_W];

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    rgb9e5_chan #(
      .MANT_W   (MANT_W),
      .EXP_W    (EXP_W),
      .EXP_BIAS (EXP_BIAS)
    ) chan_i (
      .mant_i (word_i[c*MANT_W +: MANT_W]),
      .exp_i  (shared_exp),
      .fp_o   (ch_fp[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ch_q[c] <= FP_ZERO;
      else if (valid_i) ch_q[c] <= ch_fp[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      alpha_q <= FP_ZERO;
    end else begin
      valid_q <= valid_i;
      if (valid_i) alpha_q <= FP_ONE;
    end
  end

  assign valid_o = valid_q;
  assign red_o   = ch_q[0];
  assign green_o = ch_q[1];
  assign blue_o  = ch_q[2];
  assign alpha_o = alpha_q;
endmodule

// File: rtl/rgb9e5_decode_chk.sv
module rgb9e5_decode_chk
  import rgb9e5_pkg::*;
#(
  parameter int unsigned MANT_W  = 9,
  parameter int unsigned EXP_W   = 5,
  localparam int unsigned WORD_W = NUM_CH * MANT_W + EXP_W,
  localparam int unsigned LOW_W  = FP_FRAC_W - (MANT_W - 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] word_i,
  input logic              valid_o,
  input logic [FP_W-1:0]   red_o,
  input logic [FP_W-1:0]   green_o,
  input logic [FP_W-1:0]   blue_o,
  input logic [FP_W-1:0]   alpha_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && red_o == FP_ZERO && alpha_o == FP_ZERO));

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r4_red_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i[MANT_W-1:0] == '0) |=> red_o == FP_ZERO);

  a_r4_green_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i[2*MANT_W-1:MANT_W] == '0) |=> green_o == FP_ZERO);

  a_r4_blue_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i[3*MANT_W-1:2*MANT_W] == '0) |=> blue_o == FP_ZERO);

  a_r5_sign_low_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!red_o[FP_W-1] && !green_o[FP_W-1] && !blue_o[FP_W-1] &&
                 red_o[LOW_W-1:0] == '0 && green_o[LOW_W-1:0] == '0 &&
                 blue_o[LOW_W-1:0] == '0));

  a_r6_smallest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i[WORD_W-1 -: EXP_W] == '0 && word_i[MANT_W-1:0] == MANT_W'(1))
    |=> red_o == 32'h3380_0000);

  a_r7_alpha_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> alpha_o == FP_ONE);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(red_o) && $stable(green_o) && $stable(blue_o) && $stable(alpha_o)));
endmodule

bind rgb9e5_decode rgb9e5_decode_chk #(
  .MANT_W (MANT_W),
  .EXP_W  (EXP_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .word_i  (word_i),
  .valid_o (valid_o),
  .red_o   (red_o),
  .green_o (green_o),
  .blue_o  (blue_o),
  .alpha_o (alpha_o)
);

// File: tb/rgb9e5_decode_tb_top.sv
module rgb9e5_decode_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        valid_o;
  logic [31:0] red_o, green_o, blue_o, alpha_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  rgb9e5_decode dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .word_i  (word_i),
    .valid_o (valid_o),
    .red_o   (red_o),
    .green_o (green_o),
    .blue_o  (blue_o),
    .alpha_o (alpha_o)
  );

  // expected float for mantissa m and shared exponent e (R4, R5, R6)
  function automatic logic [31:0] exp_fp(input logic [8:0] m, input logic [4:0] e);
    int k;
    logic [31:0] wide;
    if (m == 0) return 32'h0;
    k = 0;
    for (int i = 0; i < 9; i++) if (m[i]) k = i;
    wide = 32'(m) << (23 - k);
    return {1'b0, 8'(int'(e) + k + 103), wide[22:0]};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // apply one valid word, sample after the capturing edge
  task automatic apply(input logic [31:0] w, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1;
    word_i  = w;
    @(negedge clk_i);
    valid_i = 1'b0;
    cmp({tag, " R2 valid"}, 32'(valid_o), 32'h1);
    cmp({tag, " R3/R5 red"},   red_o,   exp_fp(w[8:0],   w[31:27]));
    cmp({tag, " R3/R5 green"}, green_o, exp_fp(w[17:9],  w[31:27]));
    cmp({tag, " R3/R5 blue"},  blue_o,  exp_fp(w[26:18], w[31:27]));
    cmp({tag, " R7 alpha"},    alpha_o, 32'h3F80_0000);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held_r, held_g, held_b;
    void'($urandom(32'd20240611));
    // R1 reset state
    #3;
    cmp("R1 valid in reset", 32'(valid_o), 32'h0);
    cmp("R1 red in reset", red_o, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp("R1 valid after reset", 32'(valid_o), 32'h0);
    cmp("R1 blue after reset", blue_o, 32'h0);
    cmp("R1 alpha after reset", alpha_o, 32'h0);

    // R4 zero mantissas at exponent extremes
    apply(32'hF800_0000, "R4 zero E31");
    cmp("R4 red zero E31", red_o, 32'h0);
    apply(32'h0000_0000, "R4 zero E0");

    // R6 exact values
    apply({5'd0, 9'd0, 9'd0, 9'd1}, "R6 min");
    cmp("R6 smallest", red_o, 32'h3380_0000);
    apply({5'd24, 9'd0, 9'd1, 9'd0}, "R6 one");
    cmp("R6 one green", green_o, 32'h3F80_0000);
    apply({5'd31, 9'd511, 9'd0, 9'd0}, "R6 max");
    cmp("R6 largest blue", blue_o, 32'h477F_8000);
    apply({5'd15, 9'd0, 9'd0, 9'd1}, "R6 2^-9");
    cmp("R6 red 2^-9", red_o, 32'h3B00_0000);

    // R5 each leading-one position, distinct per channel (R3 slices)
    for (int b = 0; b < 9; b++) begin
      apply({5'(b * 3), 9'(1 << b), 9'(9'h1FF >> b), 9'((1 << b) | 1)}, "R5 walk");
    end

    // R8 word ignored without valid
    apply({5'd20, 9'd300, 9'd77, 9'd5}, "R8 load");
    held_r = red_o; held_g = green_o; held_b = blue_o;
    @(negedge clk_i);
    word_i = {5'd3, 9'd1, 9'd2, 9'd3};
    @(negedge clk_i);
    cmp("R8 red held", red_o, held_r);
    cmp("R8 green held", green_o, held_g);
    cmp("R8 blue held", blue_o, held_b);
    cmp("R2 valid low", 32'(valid_o), 32'h0);

    // random words
    for (int n = 0; n < 400; n++) begin
      apply($urandom, "R3 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule